// File: doc/BRIEF.md
# Write-Clamped Charge Limit Registers

This block keeps three host-visible registers for a battery charger: a regulation-voltage code, a charge-current code and a safety register that sets a ceiling for each of them. The host writes them over a plain address, data and write-strobe bus and reads them back through a combinational read port. The operating codes are also driven out as ports for the charger datapath.

The safety register can only be changed while the battery is in its short-circuit range. A small lock state machine follows the short-range flag: state `LK_LOCKED` moves to `LK_OPEN` on transition *short_seen* (the flag is high at a clock edge). It moves back on transition *short_gone* (the flag is low at a clock edge). When the host writes an operating code above the current ceiling, the block stores the ceiling and drops the written value. A register-reset request clears the operating registers and leaves the safety register alone.

Top module: `chg_limit_regs`

## Requirements
- R1: After `rst_n` is released, address 0 reads 0x00, address 1 reads 0x00 and address 2 (safety) reads 0xFF.
- R2: Address 0 holds the 6-bit regulation-voltage code in bits 7:2. Bits 1:0 of a write are discarded and read as 0.
- R3: Address 1 holds the 4-bit charge-current code in bits 3:0. Bits 7:4 read as 0.
- R4: Address 2 holds the current limit in bits 7:4 and the voltage limit in bits 3:0.
- R5: A write to address 2 is stored only when two conditions hold together: the lock state is `LK_OPEN`, which means `batt_short` was high at the previous clock edge, and `batt_short` is high in the write cycle. Any other safety write leaves the register unchanged.
- R6: A regulation-voltage write whose code bits 5:2 exceed the voltage limit stores the code {limit, 2'b11}. Any other regulation-voltage write stores the code as written.
- R7: A charge-current write whose code exceeds the current limit stores the limit. Any other charge-current write stores the code as written.
- R8: A write to the safety register does not change the stored operating codes. New limits apply only to later writes.
- R9: `clr_req` clears both operating codes to 0 at the next edge, leaves the safety register unchanged, and wins over an operating write in the same cycle.
- R10: A write to address 3 changes nothing, and address 3 reads 0x00.
- R11: `lock_open` is high exactly when the lock state is `LK_OPEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| batt_short | input | 1 | Battery is below the short-circuit threshold |
| clr_req | input | 1 | Request to clear the operating registers |
| vreg_code | output | 6 | Stored regulation-voltage code |
| ichg_code | output | 4 | Stored charge-current code |
| lock_open | output | 1 | Safety register is writable |

## Verification
The bench builds the block with its default widths: a 6-bit voltage code against a 4-bit voltage limit, and a 4-bit current code against a 4-bit current limit. With these widths the clamp is exercised on the coarse voltage compare, where only the upper four code bits matter, and on the direct current compare. The bench checks codes exactly at, one below and above each ceiling. It also writes safety data in the cycle the flag rises and in the cycle it falls, which reaches both edges of the lock state.

// File: rtl/chg_limit_pkg.sv
package chg_limit_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_VREG = 2'd0;
    localparam logic [ADDR_W-1:0] A_ICHG = 2'd1;
    localparam logic [ADDR_W-1:0] A_SAFE = 2'd2;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/limit_clamp.sv
module limit_clamp #(
    parameter int CODE_W = 6,
    parameter int LIM_W  = 4
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic [LIM_W-1:0]  limit,
    output logic [CODE_W-1:0] code_out
);
    generate
        if (CODE_W > LIM_W) begin : g_coarse
            localparam int FILL_W = CODE_W - LIM_W;
            always_comb begin
                if (code_in[CODE_W-1 -: LIM_W] > limit)
                    code_out = {limit, {FILL_W{1'b1}}};
                else
                    code_out = code_in;
            end
        end else begin : g_direct
            always_comb begin
                if (LIM_W'(code_in) > limit)
                    code_out = CODE_W'(limit);
                else
                    code_out = code_in;
            end
        end
    endgenerate
endmodule

// File: rtl/safety_lock.sv
module safety_lock
    import chg_limit_pkg::*;
#(
    parameter int VLIM_W = 4,
    parameter int ILIM_W = 4,
    parameter logic [VLIM_W+ILIM_W-1:0] SAFE_RST = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     batt_short,
    input  logic                     safe_wr,
    input  logic [VLIM_W+ILIM_W-1:0] safe_wdata,
    output logic [VLIM_W+ILIM_W-1:0] safe_q,
    output logic                     open
);
    lock_state_t state_q, state_d;
    logic        accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (batt_short)  state_d = LK_OPEN;    // short_seen
            LK_OPEN:   if (!batt_short) state_d = LK_LOCKED;  // short_gone
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        open   = (state_q == LK_OPEN);
        accept = open && batt_short && safe_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      safe_q <= SAFE_RST;
        else if (accept) safe_q <= safe_wdata;
    end

    AST_SAFE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_short |=> $stable(safe_q)); // R5
    AST_LOCK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        batt_short |=> open); // R11
endmodule

// File: rtl/op_regs.sv
module op_regs #(
    parameter int VCODE_W = 6,
    parameter int ICODE_W = 4,
    parameter int VLIM_W  = 4,
    parameter int ILIM_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               vreg_wr,
    input  logic               ichg_wr,
    input  logic [VCODE_W-1:0] vreg_wcode,
    input  logic [ICODE_W-1:0] ichg_wcode,
    input  logic [VLIM_W-1:0]  vlim,
    input  logic [ILIM_W-1:0]  ilim,
    output logic [VCODE_W-1:0] vreg_q,
    output logic [ICODE_W-1:0] ichg_q
);
    logic [VCODE_W-1:0] vreg_cl;
    logic [ICODE_W-1:0] ichg_cl;

    limit_clamp #(.CODE_W(VCODE_W), .LIM_W(VLIM_W)) u_vclamp (
        .code_in(vreg_wcode), .limit(vlim), .code_out(vreg_cl));
    limit_clamp #(.CODE_W(ICODE_W), .LIM_W(ILIM_W)) u_iclamp (
        .code_in(ichg_wcode), .limit(ilim), .code_out(ichg_cl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vreg_q <= '0;
            ichg_q <= '0;
        end else if (clr) begin
            vreg_q <= '0;
            ichg_q <= '0;
        end else begin
            if (vreg_wr) vreg_q <= vreg_cl;
            if (ichg_wr) ichg_q <= ichg_cl;
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vreg_q == '0) && (ichg_q == '0)); // R9
    AST_VREG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_wr && !clr) |=> vreg_q[VCODE_W-1 -: VLIM_W] <= $past(vlim)); // R6
    AST_ICHG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ichg_wr && !clr) |=> ICODE_W'(ichg_q) <= ICODE_W'($past(ilim))); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !vreg_wr && !ichg_wr) |=> $stable(vreg_q) && $stable(ichg_q)); // R8
endmodule

// File: rtl/chg_limit_regs.sv
module chg_limit_regs
    import chg_limit_pkg::*;
#(
    parameter int VCODE_W = 6,
    parameter int ICODE_W = 4,
    parameter int VLIM_W  = 4,
    parameter int ILIM_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               batt_short,
    input  logic               clr_req,
    output logic [VCODE_W-1:0] vreg_code,
    output logic [ICODE_W-1:0] ichg_code,
    output logic               lock_open
);
    localparam int SAFE_W = VLIM_W + ILIM_W;

    logic [SAFE_W-1:0] safe_q;
    logic [VLIM_W-1:0] vlim;
    logic [ILIM_W-1:0] ilim;
    logic              vreg_wr, ichg_wr, safe_wr;

    always_comb begin
        vreg_wr = wr_en && (wr_addr == A_VREG);
        ichg_wr = wr_en && (wr_addr == A_ICHG);
        safe_wr = wr_en && (wr_addr == A_SAFE);
        vlim    = safe_q[VLIM_W-1:0];
        ilim    = safe_q[VLIM_W +: ILIM_W];
    end

    safety_lock #(.VLIM_W(VLIM_W), .ILIM_W(ILIM_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .batt_short(batt_short),
        .safe_wr(safe_wr), .safe_wdata(wr_data[SAFE_W-1:0]),
        .safe_q(safe_q), .open(lock_open));

    op_regs #(.VCODE_W(VCODE_W), .ICODE_W(ICODE_W),
              .VLIM_W(VLIM_W), .ILIM_W(ILIM_W)) u_ops (
        .clk(clk), .rst_n(rst_n), .clr(clr_req),
        .vreg_wr(vreg_wr), .ichg_wr(ichg_wr),
        .vreg_wcode(wr_data[DATA_W-1 -: VCODE_W]),
        .ichg_wcode(wr_data[ICODE_W-1:0]),
        .vlim(vlim), .ilim(ilim),
        .vreg_q(vreg_code), .ichg_q(ichg_code));

    always_comb begin
        unique case (rd_addr)
            A_VREG:  rd_data = {vreg_code, {(DATA_W-VCODE_W){1'b0}}};
            A_ICHG:  rd_data = DATA_W'(ichg_code);
            A_SAFE:  rd_data = DATA_W'(safe_q);
            default: rd_data = '0;
        endcase
    end

    AST_RD_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_SAFE) |-> rd_data[VLIM_W-1:0] == vlim); // R4
endmodule

// File: tb/chg_limit_regs_tb.sv
module chg_limit_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       batt_short = 1'b0;
    logic       clr_req = 1'b0;
    logic [5:0] vreg_code;
    logic [3:0] ichg_code;
    logic       lock_open;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { logic [1:0] addr; logic [7:0] exp; string req; } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    chg_limit_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .batt_short(batt_short), .clr_req(clr_req), .vreg_code(vreg_code),
        .ichg_code(ichg_code), .lock_open(lock_open));

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string r);
        item_t it;
        it.addr = a; it.exp = e; it.req = r;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic check_bit(input logic act, input logic e, input string r);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", r, act, e);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: pops expected items and compares readback between edges
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            @(negedge clk);
            rd_addr = sb_q[0].addr;
            #1;
            checks++;
            if (rd_data !== sb_q[0].exp) begin
                fails++;
                $display("FAIL %s: addr %0d got %h expected %h",
                         sb_q[0].req, sb_q[0].addr, rd_data, sb_q[0].exp);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        expect_rd(2'd0, 8'h00, "R1");
        expect_rd(2'd1, 8'h00, "R1");
        expect_rd(2'd2, 8'hFF, "R1");
        check_bit(lock_open, 1'b0, "R11");
        // R2: code 40, low bits discarded
        wr(2'd0, 8'hA3);
        expect_rd(2'd0, 8'hA0, "R2");
        // R3
        wr(2'd1, 8'hF9);
        expect_rd(2'd1, 8'h09, "R3");
        // R5: locked write rejected
        wr(2'd2, 8'h5A);
        expect_rd(2'd2, 8'hFF, "R5");
        // R5: flag rises in the write cycle, state still locked
        @(negedge clk);
        batt_short = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h11;
        @(negedge clk);
        wr_en = 1'b0;
        check_bit(lock_open, 1'b1, "R11");
        expect_rd(2'd2, 8'hFF, "R5");
        // R4/R5: open and flag high -> accepted (ilim 3, vlim 6)
        wr(2'd2, 8'h36);
        expect_rd(2'd2, 8'h36, "R4");
        // R8: operating codes not re-clamped
        expect_rd(2'd0, 8'hA0, "R8");
        expect_rd(2'd1, 8'h09, "R8");
        // R5: flag falls in write cycle while still open -> rejected
        @(negedge clk);
        batt_short = 1'b0; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        expect_rd(2'd2, 8'h36, "R5");
        check_bit(lock_open, 1'b0, "R11");
        // R6 clamp: code 63 -> {6,11}=27 -> 0x6C
        wr(2'd0, 8'hFD);
        expect_rd(2'd0, 8'h6C, "R6");
        wr(2'd0, 8'h64);  // code 25, upper bits equal limit
        expect_rd(2'd0, 8'h64, "R6");
        wr(2'd0, 8'h60);  // code 24
        expect_rd(2'd0, 8'h60, "R6");
        wr(2'd0, 8'h70);  // code 28, upper bits 7 > 6
        expect_rd(2'd0, 8'h6C, "R6");
        // R7 clamp
        wr(2'd1, 8'h0C);
        expect_rd(2'd1, 8'h03, "R7");
        wr(2'd1, 8'h03);
        expect_rd(2'd1, 8'h03, "R7");
        wr(2'd1, 8'h02);
        expect_rd(2'd1, 8'h02, "R7");
        // R10
        wr(2'd3, 8'hFF);
        expect_rd(2'd3, 8'h00, "R10");
        expect_rd(2'd0, 8'h6C, "R10");
        expect_rd(2'd1, 8'h02, "R10");
        expect_rd(2'd2, 8'h36, "R10");
        // R9 clear
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        expect_rd(2'd0, 8'h00, "R9");
        expect_rd(2'd1, 8'h00, "R9");
        expect_rd(2'd2, 8'h36, "R9");
        // R9 priority over same-cycle write
        wr(2'd1, 8'h01);
        @(negedge clk);
        clr_req = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h02;
        @(negedge clk);
        clr_req = 1'b0; wr_en = 1'b0;
        expect_rd(2'd1, 8'h00, "R9");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule